// File: doc/BRIEF.md
# Multiply-in-progress flag control

This block sits beside a processor's interrupt sequencer and looks after one bit of the status word. The bit records that a multiply or divide was cut short by an interrupt. When an interrupt is taken, the block supplies the status word and return address to be pushed. If a long arithmetic instruction was running, the return address it supplies is that instruction's own address, so the instruction is returned to and not skipped. In the status word of the new, interrupting context, the bit is set if a multiply/divide was preempted and cleared otherwise.

On return from interrupt, the block examines the bit in the current status word before the popped word replaces it. If the bit is set, it issues a one-cycle resume command to the arithmetic unit, together with the jump to the popped address. A return may be followed at once by another interrupt, with the bit set before that return. In that case the bit is set again in the new context, because the interrupted instruction had not yet resumed. The stack memory, the priority arbiter and the arithmetic engine lie outside this block.

Top module: `mip_ctl`

## Requirements
- R1: After reset the current status word `sw_q` is all zeros, and with idle inputs `push_vld`, `jump_vld`, `md_resume` and `push_seg_vld` are 0.
- R2: In a cycle with `irq_take`=1, `push_vld`=1 and `push_sw` equals `sw_q`. If `md_active`=1, `push_addr` equals `md_addr`.
- R3: After an interrupt taken with `md_active`=1, the bit of `sw_q` at position `MIP_POS` (default 9) is 1 in the next cycle, and every other bit of `sw_q` is unchanged.
- R4: An interrupt taken with `md_active`=0 pushes `next_addr`. It clears bit `MIP_POS` in the next cycle, unless R7 applies. Every other bit of `sw_q` is unchanged.
- R5: In a cycle with `reti_exec`=1, `jump_vld`=1 and `jump_addr` equals `pop_addr`. In the next cycle `sw_q` equals the `pop_sw` of that cycle.
- R6: `md_resume` is 1 exactly in a `reti_exec` cycle in which bit `MIP_POS` of `sw_q` is 1, tested before the restore. It is 0 in every other cycle.
- R7: Suppose an interrupt is taken in the cycle directly after a `reti_exec` cycle, and bit `MIP_POS` was 1 in that return cycle. Then the bit is 1 in the following cycle, whatever `md_active` is.
- R8: `push_seg_vld` is 1 only when `irq_take`=1 and `seg_en`=1. When it is 1, `push_seg` equals `cur_seg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Interrupt entry in this cycle |
| md_active | input | 1 | Current instruction is an executing multiply/divide |
| md_addr | input | ADDR_W | Address of the current multiply/divide |
| next_addr | input | ADDR_W | Address of the next instruction |
| cur_seg | input | SEG_W | Current code segment |
| seg_en | input | 1 | Segmentation enabled |
| reti_exec | input | 1 | Return-from-interrupt executing |
| pop_sw | input | SW_W | Status word popped from the stack |
| pop_addr | input | ADDR_W | Return address popped from the stack |
| push_vld | output | 1 | Push request |
| push_sw | output | SW_W | Status word to push |
| push_addr | output | ADDR_W | Return address to push |
| push_seg_vld | output | 1 | Segment is to be pushed as well |
| push_seg | output | SEG_W | Segment to push |
| sw_q | output | SW_W | Current status word |
| jump_vld | output | 1 | Jump to the popped address |
| jump_addr | output | ADDR_W | Jump target |
| md_resume | output | 1 | One-cycle resume command to the multiply/divide unit |

## Verification
The properties assume that the sequencer never raises `irq_take` and `reti_exec` in the same cycle. They also assume that `md_active` matters only while an interrupt is being taken. The bench keeps to these assumptions: it draws a single event per cycle, either an interrupt, a return or idle. The directed cases cover the preempted multiply, the return with the bit set, the back-to-back interrupt directly after that return, and a return with the bit clear. The free-running phase then mixes these patterns with varied popped words and segment settings.

// File: rtl/mip_ctl.sv
module mip_ctl #(
  parameter int SW_W    = 16,
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 8,
  parameter int MIP_POS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic              md_active,
  input  logic [ADDR_W-1:0] md_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [SEG_W-1:0]  cur_seg,
  input  logic              seg_en,
  input  logic              reti_exec,
  input  logic [SW_W-1:0]   pop_sw,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic              push_vld,
  output logic [SW_W-1:0]   push_sw,
  output logic [ADDR_W-1:0] push_addr,
  output logic              push_seg_vld,
  output logic [SEG_W-1:0]  push_seg,
  output logic [SW_W-1:0]   sw_q,
  output logic              jump_vld,
  output logic [ADDR_W-1:0] jump_addr,
  output logic              md_resume
);

  logic reti_d;
  logic mip_d;
  logic mip_next;
  logic do_reti;

  assign do_reti  = reti_exec & ~irq_take;
  assign mip_next = md_active | (reti_d & mip_d);

  assign push_vld     = irq_take;
  assign push_sw      = sw_q;
  assign push_addr    = md_active ? md_addr : next_addr;
  assign push_seg_vld = irq_take & seg_en;
  assign push_seg     = cur_seg;

  assign jump_vld  = do_reti;
  assign jump_addr = pop_addr;
  assign md_resume = do_reti & sw_q[MIP_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q   <= '0;
      reti_d <= 1'b0;
      mip_d  <= 1'b0;
    end else begin
      reti_d <= do_reti;
      if (do_reti)
        mip_d <= sw_q[MIP_POS];
      if (irq_take)
        sw_q[MIP_POS] <= mip_next;
      else if (do_reti)
        sw_q <= pop_sw;
    end
  end

endmodule

// File: rtl/mip_ctl_chk.sv
module mip_ctl_chk #(
  parameter int SW_W    = 16,
  parameter int ADDR_W  = 16,
  parameter int MIP_POS = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_take,
  input logic              md_active,
  input logic              reti_exec,
  input logic              seg_en,
  input logic [SW_W-1:0]   pop_sw,
  input logic [ADDR_W-1:0] md_addr,
  input logic [ADDR_W-1:0] push_addr,
  input logic              push_seg_vld,
  input logic [SW_W-1:0]   sw_q,
  input logic              md_resume,
  input logic              jump_vld
);

  logic c_reti, c_mip;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_reti <= 1'b0;
      c_mip  <= 1'b0;
    end else begin
      c_reti <= reti_exec && !irq_take;
      if (reti_exec && !irq_take) c_mip <= sw_q[MIP_POS];
    end
  end

  AST_PUSH_MD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && md_active |-> push_addr == md_addr); // R2
  AST_MIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && md_active |=> sw_q[MIP_POS]); // R3
  AST_MIP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && !md_active && !(c_reti && c_mip) |=> !sw_q[MIP_POS]); // R4
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    reti_exec && !irq_take |=> sw_q == $past(pop_sw)); // R5
  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    md_resume |-> jump_vld && reti_exec && !irq_take); // R6
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take && c_reti && c_mip |=> sw_q[MIP_POS]); // R7
  AST_SEG_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_seg_vld |-> irq_take && seg_en); // R8

endmodule

bind mip_ctl mip_ctl_chk #(.SW_W(SW_W), .ADDR_W(ADDR_W), .MIP_POS(MIP_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .md_active(md_active),
  .reti_exec(reti_exec), .seg_en(seg_en), .pop_sw(pop_sw), .md_addr(md_addr),
  .push_addr(push_addr), .push_seg_vld(push_seg_vld), .sw_q(sw_q),
  .md_resume(md_resume), .jump_vld(jump_vld)
);

// File: tb/test_mip_ctl.sv
module test_mip_ctl;
  localparam int SW_W = 16, ADDR_W = 16, SEG_W = 8, MIP_POS = 9;

  logic clk = 0, rst_n = 0;
  logic irq_take = 0, md_active = 0, seg_en = 0, reti_exec = 0;
  logic [ADDR_W-1:0] md_addr = '0, next_addr = '0, pop_addr = '0;
  logic [SEG_W-1:0] cur_seg = '0;
  logic [SW_W-1:0] pop_sw = '0;
  logic push_vld, push_seg_vld, jump_vld, md_resume;
  logic [SW_W-1:0] push_sw, sw_q;
  logic [ADDR_W-1:0] push_addr, jump_addr;
  logic [SEG_W-1:0] push_seg;

  int n_run = 0, n_fail = 0;
  int m_sw = 0;
  bit m_reti = 0, m_mip = 0;

  always #5 clk = ~clk;

  mip_ctl #(.SW_W(SW_W), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .MIP_POS(MIP_POS)) i_mip_ctl (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .md_active(md_active),
    .md_addr(md_addr), .next_addr(next_addr), .cur_seg(cur_seg), .seg_en(seg_en),
    .reti_exec(reti_exec), .pop_sw(pop_sw), .pop_addr(pop_addr),
    .push_vld(push_vld), .push_sw(push_sw), .push_addr(push_addr),
    .push_seg_vld(push_seg_vld), .push_seg(push_seg), .sw_q(sw_q),
    .jump_vld(jump_vld), .jump_addr(jump_addr), .md_resume(md_resume));

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mbit();
    return m_sw[MIP_POS];
  endfunction

  task automatic step(bit irq, bit md, bit reti, bit se, int psw, int paddr);
    string t;
    @(negedge clk);
    irq_take = irq; md_active = md; reti_exec = reti; seg_en = se;
    pop_sw = psw[SW_W-1:0]; pop_addr = paddr[ADDR_W-1:0];
    md_addr = ADDR_W'($urandom); next_addr = ADDR_W'($urandom);
    cur_seg = SEG_W'($urandom);
    #1;
    chk("R2 push_vld", int'(push_vld), int'(irq));
    if (irq) begin
      chk("R2 push_sw", int'(push_sw), m_sw);
      if (md) chk("R2 push_addr", int'(push_addr), int'(md_addr));
      else    chk("R4 push_addr", int'(push_addr), int'(next_addr));
    end
    chk("R8 push_seg_vld", int'(push_seg_vld), int'(irq & se));
    if (irq & se) chk("R8 push_seg", int'(push_seg), int'(cur_seg));
    chk("R5 jump_vld", int'(jump_vld), int'(reti));
    if (reti) chk("R5 jump_addr", int'(jump_addr), paddr & 16'hffff);
    chk("R6 md_resume", int'(md_resume), int'(reti & mbit()));
    if (irq) begin
      t = md ? "R3" : ((m_reti && m_mip) ? "R7" : "R4");
      m_sw[MIP_POS] = md | (m_reti & m_mip);
      m_reti = 0;
    end else if (reti) begin
      t = "R5";
      m_mip = mbit();
      m_sw = psw & 16'hffff;
      m_reti = 1;
    end else begin
      t = "R5 hold";
      m_reti = 0;
    end
    @(posedge clk); #1;
    chk({t, " sw_q"}, int'(sw_q), m_sw);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sw_q", int'(sw_q), 0);
    chk("R1 md_resume", int'(md_resume), 0);
    chk("R1 jump_vld", int'(jump_vld), 0);
    chk("R1 push_vld", int'(push_vld), 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 1, 0, 16'h00a5, 16'h0100);   // R5 load some bits
    step(1, 1, 0, 1, 0, 0);                 // R3 preempt multiply
    step(1, 0, 0, 0, 0, 0);                 // nested, non-md: R4 clear
    step(0, 0, 1, 0, 16'h02a5, 16'h0200);   // R6 no resume (bit 0), restores bit 1
    step(0, 0, 1, 0, 16'h0011, 16'h0300);   // R6 resume pulse
    step(1, 0, 0, 1, 0, 0);                 // R7 back-to-back
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 16'h0000, 16'h0400);   // R6 resume again
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);                 // R4 not back-to-back
    step(0, 0, 1, 0, 16'h0200, 16'h0500);   // bit 0 before return
    step(1, 0, 0, 0, 0, 0);                 // R4 after reti with bit 0
    for (int i = 0; i < 400; i++) begin
      int k = int'($urandom_range(0, 3));
      step(k == 1, bit'($urandom), k == 2, bit'($urandom), int'($urandom), int'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule